// File: doc/BRIEF.md
# Instruction Stream Signature Monitor

This block sits next to a processor's fetch unit and guards its control flow against injected faults. Every instruction word that enters execution is folded into a running 32-bit signature by a CRC compression step built on the Castagnoli polynomial. The step can be inverted for any given word and depends on the order of the words. A skipped, swapped or corrupted instruction therefore leaves a signature that no longer matches what the compiler predicted for that point in the program.

Decode drives two command strobes. An update strobe XORs a compiler-chosen constant into the signature, so that different paths meeting at a merge point carry the same value afterwards. A check strobe compares the signature with an expected constant. A continuous mode compares the signature on every cycle with a reference value supplied from outside, without any explicit check instruction. Any mismatch sets an alarm that stays set until reset.

Top module: `isig_monitor`

## Requirements
- R1: A cycle with rst_n low loads the signature with the seed (default 0x00000000) and clears the alarm at that clock edge.
- R2: On a cycle with instr_valid high and upd_en low, the signature becomes the CRC step of (S, I). For bit i = 0 to 31 of I, taken LSB first: fb = S[31] XOR I[i]; S = (S << 1) XOR (fb ? 0x1EDC6F41 : 0).
- R3: Absorbing word A and then word B gives a different signature from absorbing B and then A (checked with A=0x12345678, B=0x9ABCDEF0 from the seed).
- R4: Changing a single bit of one absorbed word changes the resulting signature, and the difference survives later absorbed words.
- R5: On a cycle with upd_en high, the signature becomes S XOR upd_const. If instr_valid is high in the same cycle, that instruction word is not absorbed.
- R6: When both upd_en and instr_valid are low, the signature holds its value.
- R7: When chk_en is high and chk_expect differs from the current signature, the alarm is high after the next clock edge, which is within 3 cycles of the fault. A check that matches does not raise the alarm.
- R8: When cont_en is high and ref_sig differs from the current signature, the alarm is high after the next clock edge. While cont_en is low, ref_sig has no effect on the alarm.
- R9: Once set, the alarm stays high until reset, whatever the later checks show.
- R10: Two paths that absorb different words converge to the same signature once each applies its own update constant, and a check at the merge point passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction word enters execution this cycle |
| instr_word | input | SIG_W (32) | Instruction word to absorb |
| upd_en | input | 1 | Signature-update command strobe |
| upd_const | input | SIG_W (32) | Constant XORed in by an update |
| chk_en | input | 1 | Signature-check command strobe |
| chk_expect | input | SIG_W (32) | Expected signature for a check |
| cont_en | input | 1 | Enables continuous comparison |
| ref_sig | input | SIG_W (32) | Reference signature for continuous comparison |
| sig_out | output | SIG_W (32) | Current running signature |
| alarm | output | 1 | Sticky fault alarm |

## Verification
A wrong signature register shows on sig_out at the very next clock edge. The reference model compares sig_out on every cycle, so a divergence in the CRC chain, in the update priority or in the hold behaviour is caught in the cycle it first appears. A faulty comparison or a lost sticky state shows on alarm one edge after the check or reference cycle, and the later cycles show whether it stays set. The order, corruption and convergence scenarios compare whole signature outcomes across separate runs after reset, so an error that only appears as a collision is caught as well.

// File: rtl/isig_pkg.sv
// Package: shared constants and types for the instruction stream signature monitor.
// Assumes a 32-bit signature and a polynomial given in normal (non-reflected) form.
package isig_pkg;

    localparam int          SIG_W_DEF = 32;
    localparam logic [31:0] POLY_DEF  = 32'h1EDC6F41;
    localparam logic [31:0] SEED_DEF  = 32'h0000_0000;

    // Operation applied to the signature register in a given cycle
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_UPDATE = 2'd1,
        OP_ABSORB = 2'd2
    } sig_op_e;

endpackage

// File: rtl/isig_crc_step.sv
// Module: isig_crc_step
// Combinational compression of one full instruction word into the signature.
// It chains SIG_W single-bit Galois LFSR stages and feeds the word in LSB first.
// Assumes POLY has its x^0 term set, so the step can be inverted for any word.
module isig_crc_step #(
    parameter int               SIG_W = 32,
    parameter logic [SIG_W-1:0] POLY  = 32'h1EDC6F41
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [SIG_W-1:0] word_in,
    output logic [SIG_W-1:0] sig_next
);

    localparam int STAGES = SIG_W;

    logic [SIG_W-1:0] chain [0:STAGES];

    assign chain[0] = sig_in;

    // One serial bit step per stage, data bit i enters at stage i
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic fb;
        assign fb           = chain[i][SIG_W-1] ^ word_in[i];
        assign chain[i + 1] = {chain[i][SIG_W-2:0], 1'b0} ^ ({SIG_W{fb}} & POLY);
    end

    assign sig_next = chain[STAGES];

endmodule

// File: rtl/isig_sig_reg.sv
// Module: isig_sig_reg
// Holds the running signature. An update XOR takes priority over absorbing an
// instruction in the same cycle; with neither, the value holds.
// Assumes the CRC result for the current word is supplied combinationally.
module isig_sig_reg
    import isig_pkg::*;
#(
    parameter int               SIG_W = 32,
    parameter logic [SIG_W-1:0] SEED  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic             upd_en,
    input  logic [SIG_W-1:0] upd_const,
    input  logic [SIG_W-1:0] crc_next,
    output logic [SIG_W-1:0] sig_q
);

    sig_op_e op;

    // Select this cycle's operation: update first, then absorb, else hold
    always_comb begin
        if (upd_en)           op = OP_UPDATE;
        else if (instr_valid) op = OP_ABSORB;
        else                  op = OP_HOLD;
    end

    // Signature register with synchronous active-low reset to the seed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= SEED;
        end else begin
            case (op)
                OP_UPDATE: sig_q <= sig_q ^ upd_const;
                OP_ABSORB: sig_q <= crc_next;
                default:   sig_q <= sig_q;
            endcase
        end
    end

endmodule

// File: rtl/isig_fault_flag.sv
// Module: isig_fault_flag
// Compares the current signature with an explicit expected value (on a check
// strobe) and with a reference value (while continuous mode is on). A mismatch
// sets a sticky alarm at the next clock edge. Assumes sig_q is the registered
// signature, i.e. the value before this cycle's change.
module isig_fault_flag #(
    parameter int SIG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] sig_q,
    input  logic             chk_en,
    input  logic [SIG_W-1:0] chk_expect,
    input  logic             cont_en,
    input  logic [SIG_W-1:0] ref_sig,
    output logic             alarm
);

    logic chk_miss;
    logic cont_miss;

    // Detect mismatches for both the explicit and the continuous comparison
    always_comb begin
        chk_miss  = chk_en  && (chk_expect != sig_q);
        cont_miss = cont_en && (ref_sig    != sig_q);
    end

    // Sticky alarm, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) alarm <= 1'b0;
        else        alarm <= alarm | chk_miss | cont_miss;
    end

endmodule

// File: rtl/isig_monitor.sv
// Module: isig_monitor (top)
// Instruction stream signature monitor: folds each executed instruction word
// into a CRC-32C signature, applies update constants from decode, and raises a
// sticky alarm on a failed explicit check or continuous comparison.
// Assumes at most one instruction word per cycle and decode strobes aligned
// with the cycle in which the command executes.
module isig_monitor
    import isig_pkg::*;
#(
    parameter int               SIG_W = SIG_W_DEF,
    parameter logic [SIG_W-1:0] POLY  = POLY_DEF,
    parameter logic [SIG_W-1:0] SEED  = SEED_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [SIG_W-1:0] instr_word,
    input  logic             upd_en,
    input  logic [SIG_W-1:0] upd_const,
    input  logic             chk_en,
    input  logic [SIG_W-1:0] chk_expect,
    input  logic             cont_en,
    input  logic [SIG_W-1:0] ref_sig,
    output logic [SIG_W-1:0] sig_out,
    output logic             alarm
);

    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] crc_next;

    isig_crc_step #(
        .SIG_W (SIG_W),
        .POLY  (POLY)
    ) u_crc (
        .sig_in   (sig_q),
        .word_in  (instr_word),
        .sig_next (crc_next)
    );

    isig_sig_reg #(
        .SIG_W (SIG_W),
        .SEED  (SEED)
    ) u_sig (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .upd_en      (upd_en),
        .upd_const   (upd_const),
        .crc_next    (crc_next),
        .sig_q       (sig_q)
    );

    isig_fault_flag #(
        .SIG_W (SIG_W)
    ) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_q      (sig_q),
        .chk_en     (chk_en),
        .chk_expect (chk_expect),
        .cont_en    (cont_en),
        .ref_sig    (ref_sig),
        .alarm      (alarm)
    );

    assign sig_out = sig_q;

endmodule

// File: rtl/isig_monitor_chk.sv
// Module: isig_monitor_chk
// Assertion checker for isig_monitor, attached by bind. Observes ports only.
module isig_monitor_chk #(
    parameter int SIG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic             upd_en,
    input logic [SIG_W-1:0] upd_const,
    input logic             chk_en,
    input logic [SIG_W-1:0] chk_expect,
    input logic             cont_en,
    input logic [SIG_W-1:0] ref_sig,
    input logic [SIG_W-1:0] sig_out,
    input logic             alarm
);

    // R5
    update_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (sig_out == ($past(sig_out) ^ $past(upd_const))));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !instr_valid) |=> $stable(sig_out));

    // R7
    check_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && (chk_expect != sig_out)) |=> alarm);

    // R8
    cont_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_en && (ref_sig != sig_out)) |=> alarm);

    // R9
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm);

    // R7
    no_false_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm && !(chk_en && (chk_expect != sig_out))
                && !(cont_en && (ref_sig != sig_out))) |=> !alarm);

endmodule

bind isig_monitor isig_monitor_chk #(
    .SIG_W (SIG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .upd_en      (upd_en),
    .upd_const   (upd_const),
    .chk_en      (chk_en),
    .chk_expect  (chk_expect),
    .cont_en     (cont_en),
    .ref_sig     (ref_sig),
    .sig_out     (sig_out),
    .alarm       (alarm)
);

// File: tb/isig_monitor_tb.sv
// Bench for isig_monitor: a behavioural reference model is stepped on every
// clock and compared with the outputs at the following falling edge.
module isig_monitor_tb;

    localparam logic [31:0] POLY = 32'h1EDC6F41;
    localparam logic [31:0] SEED = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_const = '0;
    logic        chk_en = 1'b0;
    logic [31:0] chk_expect = '0;
    logic        cont_en = 1'b0;
    logic [31:0] ref_sig = '0;
    logic [31:0] sig_out;
    logic        alarm;

    logic [31:0] sig_m = SEED;
    logic        alarm_m = 1'b0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    isig_monitor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .upd_en      (upd_en),
        .upd_const   (upd_const),
        .chk_en      (chk_en),
        .chk_expect  (chk_expect),
        .cont_en     (cont_en),
        .ref_sig     (ref_sig),
        .sig_out     (sig_out),
        .alarm       (alarm)
    );

    always #5 clk = ~clk;

    // Polynomial step as written in R2
    function automatic logic [31:0] model_crc(logic [31:0] s, logic [31:0] d);
        for (int i = 0; i < 32; i++) begin
            logic t;
            t = s[31] ^ d[i];
            s = s << 1;
            if (t) s = s ^ POLY;
        end
        return s;
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_ne(string tag, logic [31:0] a, logic [31:0] b);
        total++;
        if (a === b) begin
            bad++;
            $display("FAIL %s actual=%h expected=not %h", tag, a, b);
        end
    endtask

    // One clock: advance the model with the applied inputs, compare after the edge
    task automatic tick(string tag);
        @(posedge clk);
        if (!rst_n) begin
            sig_m   = SEED;
            alarm_m = 1'b0;
        end else begin
            if ((chk_en && chk_expect != sig_m) || (cont_en && ref_sig != sig_m))
                alarm_m = 1'b1;
            if (upd_en)           sig_m = sig_m ^ upd_const;
            else if (instr_valid) sig_m = model_crc(sig_m, instr_word);
        end
        @(negedge clk);
        check32({tag, " sig"}, sig_out, sig_m);
        check32({tag, " alarm"}, {31'b0, alarm}, {31'b0, alarm_m});
    endtask

    task automatic idle_in();
        instr_valid = 1'b0; upd_en = 1'b0; chk_en = 1'b0; cont_en = 1'b0;
        instr_word = '0; upd_const = '0; chk_expect = '0; ref_sig = '0;
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 1'b0;
        tick("R1 reset");
        rst_n = 1'b1;
    endtask

    task automatic absorb(logic [31:0] w, string tag);
        instr_valid = 1'b1; instr_word = w;
        tick(tag);
        idle_in();
    endtask

    initial begin
        logic [31:0] s_ab, s_ba, s_good, s_bad, tgt, c1, c2;
        // R1: reset state
        do_reset();
        check32("R1 seed", sig_out, SEED);
        check32("R1 alarm clear", {31'b0, alarm}, 32'd0);

        // R2: absorb several word patterns
        absorb(32'h0000_0000, "R2 zero word");
        absorb(32'hFFFF_FFFF, "R2 ones word");
        absorb(32'h0000_0001, "R2 lsb word");
        absorb(32'h8000_0000, "R2 msb word");
        for (int k = 0; k < 20; k++) absorb(32'hA5A5_0000 + k * 32'h0101_3779, "R2 stream");
        check32("R2 vs model", sig_out, sig_m);

        // R3: order sensitivity
        do_reset();
        absorb(32'h1234_5678, "R3 A");
        absorb(32'h9ABC_DEF0, "R3 B");
        s_ab = sig_out;
        do_reset();
        absorb(32'h9ABC_DEF0, "R3 B");
        absorb(32'h1234_5678, "R3 A");
        s_ba = sig_out;
        check_ne("R3 AB vs BA", s_ab, s_ba);

        // R4: single bit corruption propagates through later words
        do_reset();
        absorb(32'hCAFE_0001, "R4 good");
        absorb(32'h0BAD_F00D, "R4 tail");
        absorb(32'h5555_AAAA, "R4 tail");
        s_good = sig_out;
        do_reset();
        absorb(32'hCAFE_0000, "R4 flipped");
        absorb(32'h0BAD_F00D, "R4 tail");
        absorb(32'h5555_AAAA, "R4 tail");
        s_bad = sig_out;
        check_ne("R4 corrupted", s_bad, s_good);

        // R5: update XOR with an instruction offered in the same cycle
        s_good = sig_out;
        upd_en = 1'b1; upd_const = 32'h0F0F_1234;
        instr_valid = 1'b1; instr_word = 32'hDEAD_BEEF;
        tick("R5 update priority");
        idle_in();
        check32("R5 xor only", sig_out, s_good ^ 32'h0F0F_1234);

        // R6: hold when idle, with data on the bus but valid low
        s_good = sig_out;
        instr_word = 32'h1357_9BDF;
        tick("R6 idle");
        tick("R6 idle");
        check32("R6 held", sig_out, s_good);
        idle_in();

        // R7: matching check does not alarm, mismatch alarms next edge
        chk_en = 1'b1; chk_expect = sig_out;
        tick("R7 match");
        check32("R7 no alarm", {31'b0, alarm}, 32'd0);
        chk_expect = sig_out ^ 32'h0000_0100;
        tick("R7 mismatch");
        check32("R7 alarm raised", {31'b0, alarm}, 32'd1);

        // R9: sticky through matching checks and activity
        chk_expect = sig_out;
        tick("R9 sticky");
        idle_in();
        absorb(32'h2468_ACE0, "R9 sticky");
        tick("R9 sticky");
        check32("R9 still set", {31'b0, alarm}, 32'd1);

        // R8: reference ignored while off, mismatch alarms while on
        do_reset();
        cont_en = 1'b0; ref_sig = 32'hFFFF_0000;
        tick("R8 off");
        tick("R8 off");
        check32("R8 ignored", {31'b0, alarm}, 32'd0);
        ref_sig = sig_out; cont_en = 1'b1;
        tick("R8 match");
        check32("R8 match no alarm", {31'b0, alarm}, 32'd0);
        ref_sig = sig_out ^ 32'h8000_0000;
        tick("R8 mismatch");
        check32("R8 alarm raised", {31'b0, alarm}, 32'd1);
        idle_in();

        // R10: two paths converge via update constants
        tgt = 32'h7E57_C0DE;
        c1  = model_crc(SEED, 32'h1111_2222) ^ tgt;
        c2  = model_crc(SEED, 32'h3333_4444) ^ tgt;
        do_reset();
        absorb(32'h1111_2222, "R10 path1");
        upd_en = 1'b1; upd_const = c1;
        tick("R10 path1 update");
        idle_in();
        check32("R10 path1 merge", sig_out, tgt);
        chk_en = 1'b1; chk_expect = tgt;
        tick("R10 path1 check");
        idle_in();
        do_reset();
        absorb(32'h3333_4444, "R10 path2");
        upd_en = 1'b1; upd_const = c2;
        tick("R10 path2 update");
        idle_in();
        check32("R10 path2 merge", sig_out, tgt);
        chk_en = 1'b1; chk_expect = tgt;
        tick("R10 path2 check");
        idle_in();
        check32("R10 no alarm", {31'b0, alarm}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule